// File: doc/BRIEF.md
# Packed float round-to-integral unit

This block takes a 128-bit vector holding four IEEE-754 single-precision numbers and rounds every lane to an integral value. The result stays in single-precision format, not an integer encoding. An 8-bit control byte travels with each operand. It picks the rounding direction, either from its own two-bit field or from a global rounding-mode input. It also decides whether an inexact result is reported. A flush input turns denormal operands into signed zeros before rounding.

Operands enter on a valid/ready stream and leave one cycle later on a second valid/ready stream, together with two vector flags: invalid and inexact. Back-pressure rules: the input handshake completes on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the result and its flags are held unchanged. The control byte, the global mode and the flush input are sampled in the accepting cycle.

Top module: `fround_vec`

## Requirements
- R1: Each of the four 32-bit lanes (bits [31:0], [63:32], [95:64], [127:96]) is rounded on its own to an integral single-precision value. A finite input whose unbiased exponent is 23 or more, a zero, an infinity or a quiet NaN is returned bit-for-bit unchanged.
- R2: The mode encoding is 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. Control bit 2 = 0 takes the mode from control bits [1:0]. Control bit 2 = 1 takes it from `glb_mode`.
- R3: Control bits [7:4] have no effect. The control field affects only its own operation: a following operation with bit 2 = 0 uses its own bits [1:0], whatever mode was used before.
- R4: With control bit 3 = 0, `out_inexact` is 1 exactly when some lane had a nonzero fraction that rounding discarded. With bit 3 = 1, `out_inexact` is 0.
- R5: A signaling NaN (exponent all ones, mantissa nonzero, mantissa bit 22 clear) comes out with mantissa bit 22 set and every other bit kept, and it sets `out_invalid`. No other input sets `out_invalid`.
- R6: With `flush_denorm` = 1, a denormal lane becomes zero of the same sign, and it raises no inexact. With `flush_denorm` = 0, a denormal is rounded as a tiny nonzero value. No denormal flag exists.
- R7: A nonzero lane with magnitude below 1 returns a zero of its own sign, or a one of its own sign (0x3F800000 / 0xBF800000), depending on the mode. A magnitude of exactly 0.5 rounds to zero under the nearest mode.
- R8: Rounding up that carries out of the mantissa raises the exponent correctly (for example 0x3FFFFFFF gives 0x40000000 in the nearest mode).
- R9: A result appears one cycle after acceptance. `in_ready` is high when the output is empty. A result held under back-pressure keeps its data and flags stable.
- R10: While reset is asserted and after its release, `out_valid` is 0 until an operand is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_data | input | 128 | Four packed single-precision lanes |
| in_ctrl | input | 8 | Bits [1:0] mode, bit 2 use global mode, bit 3 mute inexact, [7:4] unused |
| glb_mode | input | 2 | Global rounding mode, same encoding as bits [1:0] |
| flush_denorm | input | 1 | Replace denormal inputs by signed zero |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 128 | Four rounded lanes |
| out_invalid | output | 1 | OR over lanes of signaling-NaN input |
| out_inexact | output | 1 | OR over lanes of discarded fraction, unless muted |

## Verification
The only internal state is the output register and its valid bit. A wrong mode choice, a bad fraction mask or a lost carry therefore shows at the ports in the single cycle after acceptance, as a wrong lane value or flag. A fault in the valid bit or in the hold logic shows as a result that changes under back-pressure, is duplicated, or is lost the cycle after the stall. The stimulus places distinct values in different lanes, so a lane that is swapped or uses a neighbour's control is exposed by the same output word.

// File: rtl/fround_pkg.sv
package fround_pkg;
  localparam int FP_W   = 32;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int BIAS   = 127;
  localparam int FRAC_TOP = BIAS + MAN_W;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;
endpackage

// File: rtl/fround_mode_sel.sv
module fround_mode_sel
  import fround_pkg::*;
(
  input  logic [2:0] ctrl_lo,
  input  logic [1:0] glb_mode,
  output rmode_e     mode
);
  always_comb begin
    if (ctrl_lo[2]) mode = rmode_e'(glb_mode);
    else            mode = rmode_e'(ctrl_lo[1:0]);
  end
endmodule

// File: rtl/fround_lane.sv
module fround_lane
  import fround_pkg::*;
(
  input  logic [FP_W-1:0] a,
  input  rmode_e          mode,
  input  logic            flush_dn,
  output logic [FP_W-1:0] y,
  output logic            snan,
  output logic            inexact
);
  localparam logic [EXP_W-1:0] EXP_MAX  = {EXP_W{1'b1}};
  localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EXP_HALF = EXP_W'(BIAS - 1);
  localparam logic [EXP_W-1:0] EXP_INT  = EXP_W'(FRAC_TOP);
  localparam int MAG_W = FP_W - 1;

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  logic [EXP_W-1:0] fb_full;
  logic [4:0]       fb;
  logic [MAG_W-1:0] mag, mask, step, half, rem, keep;
  logic             up, odd;

  always_comb begin
    sgn     = a[FP_W-1];
    ex      = a[FP_W-2 -: EXP_W];
    mn      = a[MAN_W-1:0];
    mag     = a[MAG_W-1:0];
    fb_full = EXP_INT - ex;
    fb      = fb_full[4:0];
    step    = MAG_W'(1) << fb;
    mask    = step - MAG_W'(1);
    half    = step >> 1;
    rem     = mag & mask;
    keep    = mag & ~mask;
    odd     = (mag & step) != '0;
    up      = 1'b0;
    y       = a;
    snan    = 1'b0;
    inexact = 1'b0;

    if (ex == EXP_MAX) begin
      if (mn != '0 && !mn[MAN_W-1]) begin
        snan = 1'b1;
        y    = {sgn, EXP_MAX, 1'b1, mn[MAN_W-2:0]};
      end
    end else if (ex == '0 && (mn == '0 || flush_dn)) begin
      y = {sgn, {MAG_W{1'b0}}};
    end else if (ex >= EXP_INT) begin
      y = a;
    end else if (ex < EXP_ONE) begin
      case (mode)
        RM_NEAR: up = (ex == EXP_HALF) && (mn != '0);
        RM_DOWN: up = sgn;
        RM_UP:   up = !sgn;
        default: up = 1'b0;
      endcase
      inexact = 1'b1;
      y = up ? {sgn, EXP_ONE, {MAN_W{1'b0}}} : {sgn, {MAG_W{1'b0}}};
    end else begin
      case (mode)
        RM_NEAR: up = (rem > half) || (rem == half && odd);
        RM_DOWN: up = sgn  && (rem != '0);
        RM_UP:   up = !sgn && (rem != '0);
        default: up = 1'b0;
      endcase
      inexact = rem != '0;
      y = {sgn, keep + (up ? step : '0)};
    end
  end
endmodule

// File: rtl/fround_vec.sv
module fround_vec
  import fround_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [LANES*FP_W-1:0] in_data,
  input  logic [7:0]            in_ctrl,
  input  logic [1:0]            glb_mode,
  input  logic                  flush_denorm,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [LANES*FP_W-1:0] out_data,
  output logic                  out_invalid,
  output logic                  out_inexact
);
  localparam int VW = LANES * FP_W;

  rmode_e           mode;
  logic [VW-1:0]    res;
  logic [LANES-1:0] lane_snan, lane_inx;
  logic             any_snan, any_inx, take;
  logic             ctrl_hi_unused;

  assign ctrl_hi_unused = ^in_ctrl[7:4];

  fround_mode_sel i_mode (
    .ctrl_lo  (in_ctrl[2:0]),
    .glb_mode (glb_mode),
    .mode     (mode)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fround_lane i_lane (
      .a        (in_data[g*FP_W +: FP_W]),
      .mode     (mode),
      .flush_dn (flush_denorm),
      .y        (res[g*FP_W +: FP_W]),
      .snan     (lane_snan[g]),
      .inexact  (lane_inx[g])
    );
  end

  assign any_snan = |lane_snan;
  assign any_inx  = (|lane_inx) && !in_ctrl[3];

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_data    <= res;
        out_invalid <= any_snan;
        out_inexact <= any_inx;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fround_chk.sv
module fround_chk
  import fround_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  mute,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [LANES*FP_W-1:0] out_data,
  input logic                  out_invalid,
  input logic                  out_inexact
);
  logic out_has_snan, out_has_qnan;

  always_comb begin
    out_has_snan = 1'b0;
    out_has_qnan = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (out_data[i*FP_W+MAN_W +: EXP_W] == {EXP_W{1'b1}}) begin
        if (out_data[i*FP_W+MAN_W-1])
          out_has_qnan = 1'b1;
        else if (out_data[i*FP_W +: MAN_W] != '0)
          out_has_snan = 1'b1;
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
      && $stable(out_invalid) && $stable(out_inexact));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_has_snan);

  p_inval_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> out_has_qnan);

  p_mute_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && mute |=> !out_inexact);
endmodule

bind fround_vec fround_chk #(.LANES(LANES)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .mute        (in_ctrl[3]),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_invalid (out_invalid),
  .out_inexact (out_inexact)
);

// File: tb/test_fround_vec.sv
`timescale 1ns/1ps
module test_fround_vec;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic [7:0]   in_ctrl = '0;
  logic [1:0]   glb_mode = '0;
  logic         flush_denorm = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic         out_invalid, out_inexact;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fround_vec i_fround_vec (.*);

  typedef struct packed {
    logic [31:0] x;
    logic [7:0]  ctrl;
    logic [1:0]  glb;
    logic        daz;
    logic [31:0] y;
    logic        inv;
    logic        inx;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{32'h3FC00000, 8'h00, 2'd0, 1'b0, 32'h40000000, 1'b0, 1'b1},
    '{32'h3FC00000, 8'h01, 2'd0, 1'b0, 32'h3F800000, 1'b0, 1'b1},
    '{32'h3FC00000, 8'h02, 2'd0, 1'b0, 32'h40000000, 1'b0, 1'b1},
    '{32'h3FC00000, 8'h03, 2'd0, 1'b0, 32'h3F800000, 1'b0, 1'b1},
    '{32'h40200000, 8'h00, 2'd0, 1'b0, 32'h40000000, 1'b0, 1'b1},
    '{32'hBFC00000, 8'h01, 2'd0, 1'b0, 32'hC0000000, 1'b0, 1'b1},
    '{32'hBFC00000, 8'h02, 2'd0, 1'b0, 32'hBF800000, 1'b0, 1'b1},
    '{32'hBFC00000, 8'h00, 2'd0, 1'b0, 32'hC0000000, 1'b0, 1'b1},
    '{32'h3F000000, 8'h00, 2'd0, 1'b0, 32'h00000000, 1'b0, 1'b1},
    '{32'h3F000000, 8'h02, 2'd0, 1'b0, 32'h3F800000, 1'b0, 1'b1},
    '{32'hBE99999A, 8'h03, 2'd0, 1'b0, 32'h80000000, 1'b0, 1'b1},
    '{32'hBE99999A, 8'h01, 2'd0, 1'b0, 32'hBF800000, 1'b0, 1'b1},
    '{32'h3F333333, 8'h00, 2'd0, 1'b0, 32'h3F800000, 1'b0, 1'b1},
    '{32'h40400000, 8'h00, 2'd0, 1'b0, 32'h40400000, 1'b0, 1'b0},
    '{32'h4B000001, 8'h02, 2'd0, 1'b0, 32'h4B000001, 1'b0, 1'b0},
    '{32'h3FFFFFFF, 8'h00, 2'd0, 1'b0, 32'h40000000, 1'b0, 1'b1},
    '{32'h4A800001, 8'h00, 2'd0, 1'b0, 32'h4A800000, 1'b0, 1'b1},
    '{32'h4A800001, 8'h02, 2'd0, 1'b0, 32'h4A800002, 1'b0, 1'b1},
    '{32'h7F800000, 8'h00, 2'd0, 1'b0, 32'h7F800000, 1'b0, 1'b0},
    '{32'h7FC00000, 8'h02, 2'd0, 1'b0, 32'h7FC00000, 1'b0, 1'b0},
    '{32'h7F800001, 8'h00, 2'd0, 1'b0, 32'h7FC00001, 1'b1, 1'b0},
    '{32'hFFA00000, 8'h00, 2'd0, 1'b0, 32'hFFE00000, 1'b1, 1'b0},
    '{32'h00000001, 8'h00, 2'd0, 1'b1, 32'h00000000, 1'b0, 1'b0},
    '{32'h00000001, 8'h02, 2'd0, 1'b0, 32'h3F800000, 1'b0, 1'b1},
    '{32'h00000001, 8'h00, 2'd0, 1'b0, 32'h00000000, 1'b0, 1'b1},
    '{32'h80400000, 8'h01, 2'd0, 1'b1, 32'h80000000, 1'b0, 1'b0},
    '{32'h3FC00000, 8'h04, 2'd1, 1'b0, 32'h3F800000, 1'b0, 1'b1},
    '{32'h3FC00000, 8'h07, 2'd2, 1'b0, 32'h40000000, 1'b0, 1'b1},
    '{32'h3FC00000, 8'hF1, 2'd0, 1'b0, 32'h3F800000, 1'b0, 1'b1},
    '{32'h3FC00000, 8'h08, 2'd0, 1'b0, 32'h40000000, 1'b0, 1'b0},
    '{32'h80000000, 8'h01, 2'd0, 1'b0, 32'h80000000, 1'b0, 1'b0},
    '{32'h3FC00000, 8'h00, 2'd3, 1'b0, 32'h40000000, 1'b0, 1'b1},
    '{32'h3FC00000, 8'h0C, 2'd3, 1'b0, 32'h3F800000, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [129:0] act, input logic [129:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] d, input logic [7:0] c,
                      input logic [1:0] g, input logic z);
    @(negedge clk);
    in_data = d; in_ctrl = c; glb_mode = g; flush_denorm = z;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 valid in reset", {129'b0, out_valid}, 130'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", {128'b0, out_valid, in_ready}, {128'b0, 2'b01});

    // Table: lane 0 carries the value, other lanes hold +0.0 (R1 pass-through)
    for (int i = 0; i < NV; i++) begin
      send({96'b0, VEC[i].x}, VEC[i].ctrl, VEC[i].glb, VEC[i].daz);
      check($sformatf("R1 R2 R4 R5 R6 R7 R8 vector %0d", i),
            {out_data, out_invalid, out_inexact},
            {96'b0, VEC[i].y, VEC[i].inv, VEC[i].inx});
    end

    // R1 R5: four different lanes under floor mode
    send({32'h7F800001, 32'hBFC00000, 32'h40200000, 32'h3F000000}, 8'h01, 2'd0, 1'b0);
    check("R1 mixed lanes",
          {out_data, out_invalid, out_inexact},
          {32'h7FC00001, 32'hC0000000, 32'h40000000, 32'h00000000, 1'b1, 1'b1});

    // R3 non-sticky: global floor used, then own nearest mode despite same global
    send({96'b0, 32'h3FC00000}, 8'h04, 2'd1, 1'b0);
    check("R3 global use", {out_data, out_invalid, out_inexact}, {96'b0, 32'h3F800000, 2'b01});
    send({96'b0, 32'h3FC00000}, 8'hF0, 2'd1, 1'b0);
    check("R3 own mode after global", {out_data, out_invalid, out_inexact}, {96'b0, 32'h40000000, 2'b01});

    // R9 back-pressure: hold A, offer B, then release
    @(negedge clk);
    out_ready = 1'b0;
    send({96'b0, 32'h3FC00000}, 8'h03, 2'd0, 1'b0);
    check("R9 result present", {out_data, out_valid, in_ready}, {96'b0, 32'h3F800000, 2'b10});
    in_data = {96'b0, 32'h40400000}; in_ctrl = 8'h00; in_valid = 1'b1;
    @(negedge clk);
    check("R9 held under stall", {out_data, out_valid, in_ready}, {96'b0, 32'h3F800000, 2'b10});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 next after release", {out_data, out_valid, out_inexact}, {96'b0, 32'h40400000, 2'b10});
    @(negedge clk);
    check("R9 drained", {128'b0, out_valid, in_ready}, {128'b0, 2'b01});

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule